// File: doc/BRIEF.md
# Time-Triggered Bank-Group DRAM Command Scheduler

This block is the command backend of a predictable memory controller. It takes a two-rank DRAM module with four banks per rank and splits it into four private groups. Each group owns two banks of a single rank, and neighbouring groups sit in opposite ranks. A free-running slot timer hands the command bus to the groups in a fixed round-robin order. Every group therefore gets a slot of `SLOT_LEN` cycles once per round, and its access latency never depends on traffic in the other groups.

Every access is closed-page. A slot opens a row with an activate command, and `ACT_GAP` cycles later it issues a read or write with auto-precharge, so the row is closed before the group's next slot. Refresh does not use the device's refresh command. Each group owes refresh work, counted in a debt counter, and pays it off with ordinary auto-precharge reads that walk through its rows. A pending demand request takes the slot ahead of owed refresh, so refresh is deferred, until the debt reaches `DEBT_MAX`. From then on refresh takes the slot first. A frontend keeps one request per group asserted until the block acknowledges it.

Top module: `tt_dram_sched`

## Requirements
- R1: While reset is asserted, and directly after it, `cmd_o` is NOP (code 0), `req_ack` is all zero, `cmd_refresh_o` is 0 and `slot_grp_o` is 0.
- R2: `slot_grp_o` advances by one, modulo 4, every `SLOT_LEN` cycles, whatever the request load.
- R3: Group g drives rank g[0] and bank {g[1], b}. Here b is the bank-select bit at position ROW_W+COL_W of the group's request address, above the row field [ROW_W+COL_W-1:COL_W] and the column field [COL_W-1:0]. As a result, consecutive groups alternate rank.
- R4: An accepted demand request produces an ACT command (code 1) carrying the row in `cmd_addr_o`, in the same cycle as its acknowledge. Exactly `ACT_GAP` cycles later comes a read with auto-precharge (code 2) or a write with auto-precharge (code 3), carrying the column.
- R5: `req_ack` is at most one-hot. A group is acknowledged only in the cycle its own ACT is on the bus, and only for a single cycle.
- R6: A slot whose group has no pending request and no refresh debt leaves the bus at NOP.
- R7: Every `REFI_CYC` cycles after reset, each group's refresh debt grows by one, saturating at `DEBT_MAX`. A group that has its request held continuously therefore performs exactly one refresh per `REFI_CYC` once its debt has reached the maximum.
- R8: A slot with owed refresh and no pending request issues ACT and then a read with auto-precharge, both with `cmd_refresh_o` = 1. The read uses column 0. The n-th refresh of a group (counting from 0 after reset) uses bank-select n mod 2 and row n/2.
- R9: While a group's debt is below `DEBT_MAX`, a pending request takes the group's slot ahead of owed refresh.
- R10: When a group's debt equals `DEBT_MAX` at the start of its slot, the slot issues a refresh even if a request is pending.
- R11: Every read or write command follows, exactly `ACT_GAP` cycles earlier, an ACT to the same rank and bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 4 | Per-group request pending, held until acknowledged |
| req_write | input | 4 | Per-group request is a write |
| req_addr | input | 4*(ROW_W+COL_W+1) | Per-group address {bank-select, row, column}, group g at slice g |
| req_ack | output | 4 | Per-group one-cycle acknowledge |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 read+AP, 3 write+AP |
| cmd_rank_o | output | 1 | Rank of the command |
| cmd_bank_o | output | 2 | Bank within the rank |
| cmd_addr_o | output | ROW_W | Row on ACT, zero-extended column on read/write |
| cmd_refresh_o | output | 1 | Command belongs to a refresh read |
| slot_grp_o | output | 2 | Group that owns the current slot |

## Verification
Several properties are checked on every cycle: the rotation of the slot timer, the upper bound on each debt counter, the rule that refresh is taken only when owed, the one-hot acknowledge, the fixed ACT-to-column gap on the same bank, and the slot-start choices between demand, refresh and idle. The scenarios cover the rest. They check the address mapping for each group, the sequence of refresh rows, and the exact number of demand and refresh slots a continuously requesting group receives before and after its debt saturates. These are cumulative, long-range effects that no single-cycle property captures.

// File: rtl/tts_pkg.sv
package tts_pkg;
  localparam int NUM_GRP = 4;
  localparam int GRP_W   = 2;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RDA = 3'd2,
    CMD_WRA = 3'd3
  } cmd_e;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_DEMAND  = 2'd1,
    OP_REFRESH = 2'd2
  } op_e;

  // rank owned by a group: neighbours alternate
  function automatic logic grp_rank(input logic [GRP_W-1:0] g);
    return g[0];
  endfunction

  // bank inside the rank: upper bit from group, lower bit from the access
  function automatic logic [1:0] grp_bank(input logic [GRP_W-1:0] g, input logic sel);
    return {g[1], sel};
  endfunction

  // slot-start decision
  function automatic op_e pick_op(input logic pend, input logic owed, input logic full);
    if (full)      return OP_REFRESH;
    else if (pend) return OP_DEMAND;
    else if (owed) return OP_REFRESH;
    else           return OP_IDLE;
  endfunction
endpackage

// File: rtl/tts_slot_timer.sv
module tts_slot_timer
  import tts_pkg::*;
#(
  parameter int SLOT_LEN = 8,
  parameter int ACT_GAP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [GRP_W-1:0] grp,
  output logic             decide,
  output logic             issue
);
  localparam int OFS_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam logic [OFS_W-1:0] LAST_OFS  = OFS_W'(SLOT_LEN - 1);
  localparam logic [OFS_W-1:0] ISSUE_OFS = OFS_W'(ACT_GAP);

  logic [OFS_W-1:0] ofs_q;
  logic [GRP_W-1:0] grp_q;
  logic             slot_end;

  assign slot_end = (ofs_q == LAST_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      grp_q <= '0;
    end else if (slot_end) begin
      ofs_q <= '0;
      grp_q <= grp_q + 1'b1;
    end else begin
      ofs_q <= ofs_q + 1'b1;
    end
  end

  assign grp    = grp_q;
  assign decide = (ofs_q == '0);
  assign issue  = (ofs_q == ISSUE_OFS);

  // R2
  slot_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (grp_q == GRP_W'($past(grp_q) + 1'b1)) && decide);

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(grp_q));
endmodule

// File: rtl/tts_refresh_ledger.sv
module tts_refresh_ledger
  import tts_pkg::*;
#(
  parameter int REFI_CYC = 1950,
  parameter int DEBT_MAX = 8,
  parameter int PTR_W    = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GRP-1:0]         take,
  output logic [NUM_GRP-1:0]         owed,
  output logic [NUM_GRP-1:0]         full,
  output logic [NUM_GRP*PTR_W-1:0]   ptr
);
  localparam int TMR_W  = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam int DEBT_W = $clog2(DEBT_MAX + 1);
  localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(REFI_CYC - 1);
  localparam logic [DEBT_W-1:0] DEBT_TOP = DEBT_W'(DEBT_MAX);

  logic [TMR_W-1:0] tmr_q;
  logic             tick;

  assign tick = (tmr_q == TMR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmr_q <= '0;
    else if (tick) tmr_q <= '0;
    else           tmr_q <= tmr_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [DEBT_W-1:0] debt_q;
    logic [PTR_W-1:0]  ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        debt_q <= '0;
      end else if (tick && !take[g]) begin
        if (debt_q != DEBT_TOP) debt_q <= debt_q + 1'b1;
      end else if (!tick && take[g]) begin
        debt_q <= debt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (take[g]) ptr_q <= ptr_q + 1'b1;
    end

    assign owed[g] = (debt_q != '0);
    assign full[g] = (debt_q == DEBT_TOP);
    assign ptr[g*PTR_W +: PTR_W] = ptr_q;

    // R7
    debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      debt_q <= DEBT_TOP);

    // R8
    take_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take[g] |-> (debt_q != '0));
  end
endmodule

// File: rtl/tts_op_select.sv
module tts_op_select
  import tts_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int PTR_W = ROW_W + 1
) (
  input  logic [GRP_W-1:0]                       grp,
  input  logic [NUM_GRP-1:0]                     req_valid,
  input  logic [NUM_GRP-1:0]                     req_write,
  input  logic [NUM_GRP*(ROW_W+COL_W+1)-1:0]     req_addr,
  input  logic [NUM_GRP-1:0]                     owed,
  input  logic [NUM_GRP-1:0]                     full,
  input  logic [NUM_GRP*PTR_W-1:0]               ptr,
  output op_e                                    op,
  output logic                                   wr,
  output logic                                   rank,
  output logic [1:0]                             bank,
  output logic [ROW_W-1:0]                       row,
  output logic [COL_W-1:0]                       col
);
  localparam int ADDR_W = ROW_W + COL_W + 1;

  logic [ADDR_W-1:0] a;
  logic [PTR_W-1:0]  p;

  assign a  = req_addr[grp*ADDR_W +: ADDR_W];
  assign p  = ptr[grp*PTR_W +: PTR_W];
  assign op = pick_op(req_valid[grp], owed[grp], full[grp]);

  always_comb begin
    rank = grp_rank(grp);
    if (op == OP_REFRESH) begin
      wr   = 1'b0;
      bank = grp_bank(grp, p[0]);
      row  = p[PTR_W-1:1];
      col  = '0;
    end else begin
      wr   = req_write[grp];
      bank = grp_bank(grp, a[ADDR_W-1]);
      row  = a[COL_W +: ROW_W];
      col  = a[COL_W-1:0];
    end
  end
endmodule

// File: rtl/tt_dram_sched.sv
module tt_dram_sched
  import tts_pkg::*;
#(
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int SLOT_LEN = 8,
  parameter int ACT_GAP  = 3,
  parameter int REFI_CYC = 1950,
  parameter int DEBT_MAX = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [3:0]                             req_valid,
  input  logic [3:0]                             req_write,
  input  logic [4*(ROW_W+COL_W+1)-1:0]           req_addr,
  output logic [3:0]                             req_ack,
  output logic [2:0]                             cmd_o,
  output logic                                   cmd_rank_o,
  output logic [1:0]                             cmd_bank_o,
  output logic [ROW_W-1:0]                       cmd_addr_o,
  output logic                                   cmd_refresh_o,
  output logic [1:0]                             slot_grp_o
);
  localparam int PTR_W = ROW_W + 1;

  logic [GRP_W-1:0]          grp;
  logic                      decide, issue;
  logic [NUM_GRP-1:0]        owed, full, take, grp_oh;
  logic [NUM_GRP*PTR_W-1:0]  ptr;
  op_e                       sel_op;
  logic                      sel_wr, sel_rank;
  logic [1:0]                sel_bank;
  logic [ROW_W-1:0]          sel_row;
  logic [COL_W-1:0]          sel_col;

  tts_slot_timer #(.SLOT_LEN(SLOT_LEN), .ACT_GAP(ACT_GAP)) u_timer (
    .clk(clk), .rst_n(rst_n), .grp(grp), .decide(decide), .issue(issue));

  tts_refresh_ledger #(.REFI_CYC(REFI_CYC), .DEBT_MAX(DEBT_MAX), .PTR_W(PTR_W)) u_ledger (
    .clk(clk), .rst_n(rst_n), .take(take), .owed(owed), .full(full), .ptr(ptr));

  tts_op_select #(.ROW_W(ROW_W), .COL_W(COL_W), .PTR_W(PTR_W)) u_sel (
    .grp(grp), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .owed(owed), .full(full), .ptr(ptr), .op(sel_op), .wr(sel_wr), .rank(sel_rank),
    .bank(sel_bank), .row(sel_row), .col(sel_col));

  assign grp_oh = NUM_GRP'(1) << grp;
  assign take   = (decide && sel_op == OP_REFRESH) ? grp_oh : '0;

  // operation held for the column command of the slot
  op_e              op_q;
  logic             op_wr_q, op_rank_q;
  logic [1:0]       op_bank_q;
  logic [COL_W-1:0] op_col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_IDLE;
      op_wr_q   <= 1'b0;
      op_rank_q <= 1'b0;
      op_bank_q <= '0;
      op_col_q  <= '0;
    end else if (decide) begin
      op_q      <= sel_op;
      op_wr_q   <= sel_wr;
      op_rank_q <= sel_rank;
      op_bank_q <= sel_bank;
      op_col_q  <= sel_col;
    end
  end

  cmd_e             cmd_q;
  logic             rank_q, ref_q;
  logic [1:0]       bank_q;
  logic [ROW_W-1:0] addr_q;
  logic [3:0]       ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      rank_q <= 1'b0;
      bank_q <= '0;
      addr_q <= '0;
      ref_q  <= 1'b0;
      ack_q  <= '0;
    end else begin
      cmd_q  <= CMD_NOP;
      rank_q <= 1'b0;
      bank_q <= '0;
      addr_q <= '0;
      ref_q  <= 1'b0;
      ack_q  <= '0;
      if (decide && sel_op != OP_IDLE) begin
        cmd_q  <= CMD_ACT;
        rank_q <= sel_rank;
        bank_q <= sel_bank;
        addr_q <= sel_row;
        ref_q  <= (sel_op == OP_REFRESH);
        ack_q  <= (sel_op == OP_DEMAND) ? grp_oh : '0;
      end else if (issue && op_q != OP_IDLE) begin
        cmd_q  <= op_wr_q ? CMD_WRA : CMD_RDA;
        rank_q <= op_rank_q;
        bank_q <= op_bank_q;
        addr_q <= ROW_W'(op_col_q);
        ref_q  <= (op_q == OP_REFRESH);
      end
    end
  end

  assign req_ack       = ack_q;
  assign cmd_o         = cmd_q;
  assign cmd_rank_o    = rank_q;
  assign cmd_bank_o    = bank_q;
  assign cmd_addr_o    = addr_q;
  assign cmd_refresh_o = ref_q;
  assign slot_grp_o    = grp;

  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ack) && ((req_ack != '0) -> (cmd_q == CMD_ACT)));

  // R9
  demand_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req_valid[grp] && !full[grp]) |=> (req_ack == $past(grp_oh)) && !cmd_refresh_o);

  // R10
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && full[grp]) |=> (cmd_q == CMD_ACT) && cmd_refresh_o && (req_ack == '0));

  // R6
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !req_valid[grp] && !owed[grp]) |=> (cmd_q == CMD_NOP));

  // R11
  col_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RDA || cmd_q == CMD_WRA) |->
      ($past(cmd_q, ACT_GAP) == CMD_ACT) && ($past(bank_q, ACT_GAP) == bank_q) &&
      ($past(rank_q, ACT_GAP) == rank_q));

  // R8
  refresh_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_refresh_o && cmd_q != CMD_ACT) |-> (cmd_q == CMD_RDA) && (addr_q == '0));
endmodule

// File: tb/tt_dram_sched_tb.sv
module tt_dram_sched_tb;
  localparam int ROW_W = 14, COL_W = 10, ADDR_W = ROW_W + COL_W + 1;
  localparam int SLOT_LEN = 8, ACT_GAP = 3, REFI = 200, DMAX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] req_valid = '0, req_write = '0;
  logic [4*ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_ack;
  logic [2:0] cmd_o;
  logic cmd_rank_o, cmd_refresh_o;
  logic [1:0] cmd_bank_o, slot_grp_o;
  logic [ROW_W-1:0] cmd_addr_o;

  tt_dram_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .SLOT_LEN(SLOT_LEN), .ACT_GAP(ACT_GAP),
                  .REFI_CYC(REFI), .DEBT_MAX(DMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ack(req_ack), .cmd_o(cmd_o), .cmd_rank_o(cmd_rank_o),
    .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o), .cmd_refresh_o(cmd_refresh_o),
    .slot_grp_o(slot_grp_o));

  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0, n_bad = 0, cyc = 0, rcyc = 0;
  int ref_cnt [4];
  int dem_cnt [4];
  int last_act = -100;
  bit done = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {grp[27:26], wr[25], bsel[24], row[23:10], col[9:0]}
  localparam logic [27:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 14'h0123, 10'h045},
    {2'd1, 1'b1, 1'b1, 14'h3FFF, 10'h3FF},
    {2'd2, 1'b0, 1'b1, 14'h0000, 10'h001},
    {2'd3, 1'b1, 1'b0, 14'h2A5A, 10'h155},
    {2'd3, 1'b0, 1'b1, 14'h1111, 10'h200},
    {2'd2, 1'b1, 1'b0, 14'h0F0F, 10'h0AA},
    {2'd1, 1'b0, 1'b0, 14'h0001, 10'h000},
    {2'd0, 1'b1, 1'b1, 14'h3000, 10'h3C3}
  };

  always @(posedge clk) begin
    cyc++;
    if (rst_n) rcyc++; else rcyc = 0;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // bus monitor: refresh row walk (R8) and column timing (R11)
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 4; g++) begin ref_cnt[g] = 0; dem_cnt[g] = 0; end
      last_act = -100;
    end else if (cmd_o == 3'd1) begin
      automatic int g = cmd_bank_o[1] * 2 + int'(cmd_rank_o);
      last_act = rcyc;
      if (cmd_refresh_o) begin
        check({31'd0, cmd_bank_o[0]}, ref_cnt[g] % 2, "R8 refresh bank-select");
        check(32'(cmd_addr_o), ref_cnt[g] / 2, "R8 refresh row");
        ref_cnt[g]++;
      end else dem_cnt[g]++;
    end else if (cmd_o == 3'd2 || cmd_o == 3'd3) begin
      check(rcyc - last_act, ACT_GAP, "R11 ACT to column gap");
      if (cmd_refresh_o) check({29'd0, cmd_o} * 1000 + 32'(cmd_addr_o), 2000, "R8 refresh read col 0");
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = '0;
    repeat (3) @(negedge clk);
    check(cmd_o, 0, "R1 cmd NOP in reset");
    check(req_ack, 0, "R1 no ack in reset");
    check(slot_grp_o, 0, "R1 slot group 0");
    check(cmd_refresh_o, 0, "R1 refresh flag low");
    rst_n = 1'b1;
  endtask

  task automatic wait_rcyc(input int n);
    while (rcyc < n) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R6: idle bus while no request and no debt
    begin
      int busy = 0;
      repeat (150) begin @(negedge clk); if (cmd_o != 3'd0) busy++; end
      check(busy, 0, "R6 idle slots stay NOP");
    end

    // R3/R4/R5 vector table
    for (int i = 0; i < 8; i++) begin
      automatic logic [27:0] v = VEC[i];
      automatic int g = v[27:26];
      automatic int waited = 0;
      req_addr[g*ADDR_W +: ADDR_W] = {v[24], v[23:10], v[9:0]};
      req_write[g] = v[25];
      req_valid[g] = 1'b1;
      while (!req_ack[g] && waited < 64) begin @(negedge clk); waited++; end
      req_valid[g] = 1'b0;
      check(req_ack, 4'b0001 << g, "R5 single-group ack");
      check(cmd_o, 1, "R4 ACT with ack");
      check(cmd_rank_o, g % 2, "R3 rank of group");
      check(cmd_bank_o, (g / 2) * 2 + v[24], "R3 bank of group");
      check(32'(cmd_addr_o), 32'(v[23:10]), "R4 row on ACT");
      @(negedge clk);
      check(req_ack, 0, "R5 ack lasts one cycle");
      repeat (ACT_GAP - 1) @(negedge clk);
      check(cmd_o, v[25] ? 3 : 2, "R4 column command type");
      check(32'(cmd_addr_o), 32'(v[9:0]), "R4 column address");
      check(cmd_bank_o, (g / 2) * 2 + v[24], "R4 column bank");
    end

    // R2 rotation
    for (int k = 0; k < 6; k++) begin
      automatic int s = slot_grp_o;
      repeat (SLOT_LEN) @(negedge clk);
      check(slot_grp_o, (s + 1) % 4, "R2 slot rotation");
    end

    // R7/R8/R9/R10: group 1 requests without pause
    do_reset();
    req_addr[1*ADDR_W +: ADDR_W] = {1'b0, 14'h0042, 10'h010};
    req_write[1] = 1'b0;
    req_valid[1] = 1'b1;
    wait_rcyc(560);
    check(ref_cnt[1], 0, "R9 refresh deferred for busy group");
    check(dem_cnt[1], 18, "R9 busy group keeps every slot");
    check(ref_cnt[0], 2, "R8 idle group refreshes per interval");
    check(ref_cnt[2], 2, "R8 idle group 2 refreshes");
    wait_rcyc(700);
    check(ref_cnt[1], 1, "R10 refresh preempts at debt max");
    wait_rcyc(990);
    check(ref_cnt[1], 2, "R7 one refresh per interval at max");
    begin
      automatic int s = slot_grp_o;
      repeat (SLOT_LEN) @(negedge clk);
      check(slot_grp_o, (s + 1) % 4, "R2 rotation under load");
    end
    req_valid = '0;
    repeat (20) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule